// File: doc/BRIEF.md
# Two-Channel LED Dimmer Output Selector

This block drives a small set of active-low LED pads. Each pad either stays released (undriven, so an external pull-up holds it high and the LED is dark), is driven low (LED lit), or follows one of two shared dimming waveforms. Each waveform comes from its own 8-bit duty register, compared against one shared free-running 8-bit counter. A 2-bit source field per pad picks which of the four sources the pad follows.

The block has a byte-wide register port: a write strobe with address and data, plus a read-data bus decoded combinationally from the address. Address 0 returns the sampled pad levels, so a released pad can be used as a general-purpose input. Addresses 1 and 2 hold the two duty values. Address 3 holds the source fields. A duty write reads back at once, but the waveform only adopts the new value at the next counter wrap. This means a waveform period never mixes two duty values. The asynchronous reset is released to the core through a two-stage synchronizer.

Top module: `led_pwm_selector`

## Requirements
- R1: While reset is asserted, and afterwards until the core leaves reset, both pad enables are deasserted. The core leaves reset on the second rising clock edge after `rst_n` goes high. After reset both duty registers read 80h, the source register reads F0h, and the counter starts from 0.
- R2: The dimming counter is 8 bits wide. It advances by one on every clock after reset and wraps from FFh to 00h, so a waveform period is 256 clocks.
- R3: A waveform requests drive-low while the counter is strictly below its active duty value. It releases the pad when the counter is equal to or above that value.
- R4: An active duty of 00h never drives the pad low. An active duty of FFh drives it low for 255 of every 256 clocks.
- R5: Each pad has a source field in the source register: pad 0 uses bits 1:0 and pad 1 uses bits 3:2. The codes are 00 released, 01 driven low, 10 follows waveform 0 and 11 follows waveform 1.
- R6: Bits 7:4 of the source register always read as 1111, and writes to them have no effect.
- R7: A duty write reads back on the next clock. The waveform adopts the new value on the clock edge where the counter wraps from FFh to 00h. A write that lands on that same edge takes effect at that wrap.
- R8: Reading address 0 returns the pad levels on bits 1:0 (bit n is pad n) and zeros above them. Writes to address 0 have no effect.
- R9: Address map: 0 is the pad input, 1 is duty 0, 2 is duty 1, 3 is the source register. `rd_data` follows `addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the current address |
| pad_in | input | 2 | Sampled level of each pad |
| drv_low | output | 2 | Per-pad drive-low enable (1 = pull pad low, LED lit) |

## Verification
The case of interest is a duty write that arrives on the same clock edge as the counter wrap. That edge both loads the pending value and moves it into the active compare, so the write must land in the waveform without waiting a further period. The bench waits until its own model counter shows FFh and issues the write in that cycle. It then counts the low clocks over the following 256 cycles and expects them to equal the new duty. A write placed in the middle of a period is judged the same way: the bench expects the old duty for the rest of that period and the new one for the period after. The random phase also hits wraps with writes and checks every cycle against the model.

// File: rtl/led_sel_pkg.sv
package led_sel_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_ON   = 2'b01,
    SRC_WAV0 = 2'b10,
    SRC_WAV1 = 2'b11
  } src_e;

  localparam logic [ADDR_W-1:0] ADDR_PADS  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DUTY0 = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DUTY1 = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_SRC   = 2'd3;

endpackage

// File: rtl/led_rst_sync.sv
module led_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/led_tick_counter.sv
module led_tick_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt_q,
  output logic         wrap
);

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign wrap = (cnt_q == '1);

endmodule

// File: rtl/led_duty_channel.sv
module led_duty_channel #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = 8'h80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_val,
  input  logic         wrap,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] act_q,
  output logic         wave_low
);

  logic [W-1:0] pend_d;
  logic [W-1:0] act_d;
  logic         act_en;

  always_comb begin
    pend_d = wr_stb ? wr_val : pend_q;
    act_en = wrap;
    act_d  = pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= RST_VAL;
      act_q  <= RST_VAL;
    end else begin
      pend_q <= pend_d;
      if (act_en) act_q <= act_d;
    end
  end

  assign wave_low = (cnt < act_q);

endmodule

// File: rtl/led_pin_mux.sv
module led_pin_mux
  import led_sel_pkg::*;
(
  input  src_e       src,
  input  logic [1:0] wave_low,
  output logic       drv_low
);

  always_comb begin
    unique case (src)
      SRC_OFF:  drv_low = 1'b0;
      SRC_ON:   drv_low = 1'b1;
      SRC_WAV0: drv_low = wave_low[0];
      SRC_WAV1: drv_low = wave_low[1];
      default:  drv_low = 1'b0;
    endcase
  end

endmodule

// File: rtl/led_pwm_selector.sv
module led_pwm_selector
  import led_sel_pkg::*;
#(
  parameter int                NUM_PINS  = 2,
  parameter int                SYNC_STG  = 2,
  parameter logic [DATA_W-1:0] RST_DUTY0 = 8'h80,
  parameter logic [DATA_W-1:0] RST_DUTY1 = 8'h80
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] drv_low
);

  localparam int                NUM_WAV  = 2;
  localparam int                SEL_W    = 2 * NUM_PINS;
  localparam logic [DATA_W-1:0] SEL_MASK = DATA_W'((1 << SEL_W) - 1);

  logic                           core_rst_n;
  logic [DATA_W-1:0]              cnt_q;
  logic                           wrap;
  logic [NUM_WAV-1:0][DATA_W-1:0] duty_pend;
  logic [NUM_WAV-1:0][DATA_W-1:0] duty_act;
  logic [NUM_WAV-1:0]             wave_low;
  logic [SEL_W-1:0]               sel_q;
  logic [SEL_W-1:0]               sel_d;
  logic                           sel_we;

  led_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (core_rst_n)
  );

  led_tick_counter #(.W(DATA_W)) u_cnt (
    .clk   (clk),
    .rst_n (core_rst_n),
    .cnt_q (cnt_q),
    .wrap  (wrap)
  );

  for (genvar ch = 0; ch < NUM_WAV; ch++) begin : g_wav
    localparam logic [DATA_W-1:0] RV = (ch == 0) ? RST_DUTY0 : RST_DUTY1;
    logic wr_stb;
    assign wr_stb = wr_en && (addr == ADDR_W'(ch + 1));
    led_duty_channel #(.W(DATA_W), .RST_VAL(RV)) u_duty (
      .clk      (clk),
      .rst_n    (core_rst_n),
      .wr_stb   (wr_stb),
      .wr_val   (wr_data),
      .wrap     (wrap),
      .cnt      (cnt_q),
      .pend_q   (duty_pend[ch]),
      .act_q    (duty_act[ch]),
      .wave_low (wave_low[ch])
    );
  end

  always_comb begin
    sel_we = wr_en && (addr == ADDR_SRC);
    sel_d  = sel_we ? wr_data[SEL_W-1:0] : sel_q;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) sel_q <= '0;
    else             sel_q <= sel_d;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    led_pin_mux u_mux (
      .src      (src_e'(sel_q[2*p +: 2])),
      .wave_low (wave_low),
      .drv_low  (drv_low[p])
    );
  end

  always_comb begin
    unique case (addr)
      ADDR_PADS:  rd_data = DATA_W'(pad_in);
      ADDR_DUTY0: rd_data = duty_pend[0];
      ADDR_DUTY1: rd_data = duty_pend[1];
      default:    rd_data = DATA_W'(sel_q) | ~SEL_MASK;
    endcase
  end

endmodule

// File: rtl/led_pwm_selector_chk.sv
module led_pwm_selector_chk
  import led_sel_pkg::*;
#(
  parameter int NUM_PINS = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2*NUM_PINS-1:0] sel_q,
  input logic [DATA_W-1:0]     cnt_q,
  input logic [DATA_W-1:0]     act0_q,
  input logic [DATA_W-1:0]     act1_q,
  input logic [NUM_PINS-1:0]   drv_low,
  input logic [ADDR_W-1:0]     addr,
  input logic [DATA_W-1:0]     rd_data
);

  localparam logic [DATA_W-1:0] RSV = ~DATA_W'((1 << (2*NUM_PINS)) - 1);

  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> cnt_q == DATA_W'($past(cnt_q) + 1'b1));

  // R7
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && cnt_q != '0) |-> ($stable(act0_q) && $stable(act1_q)));

  // R6
  rsv_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_SRC) |-> ((rd_data & RSV) == RSV));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pchk
    // R5
    force_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[2*p +: 2] == SRC_ON) |-> drv_low[p]);
    // R5
    released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[2*p +: 2] == SRC_OFF) |-> !drv_low[p]);
    // R3
    cmp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[2*p +: 2] == SRC_WAV1 && cnt_q >= act1_q) |-> !drv_low[p]);
    // R4
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[2*p +: 2] == SRC_WAV0 && act0_q == '0) |-> !drv_low[p]);
  end

endmodule

bind led_pwm_selector led_pwm_selector_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk     (clk),
  .rst_n   (core_rst_n),
  .sel_q   (sel_q),
  .cnt_q   (cnt_q),
  .act0_q  (duty_act[0]),
  .act1_q  (duty_act[1]),
  .drv_low (drv_low),
  .addr    (addr),
  .rd_data (rd_data)
);

// File: tb/led_pwm_selector_tb_top.sv
`timescale 1ns/1ps
module led_pwm_selector_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [1:0] pad_in;
  logic [1:0] drv_low;
  logic [1:0] ext_level = 2'b11;

  int n_cmp = 0;
  int n_bad = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign pad_in = ~drv_low & ext_level;

  led_pwm_selector dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in), .drv_low(drv_low)
  );

  // Reference model built from the requirements
  logic [1:0] bq = 2'b00;
  logic [7:0] m_cnt;
  logic [7:0] m_pend [2];
  logic [7:0] m_act [2];
  logic [3:0] m_sel;

  always @(posedge clk) bq <= rst_n ? {bq[0], 1'b1} : 2'b00;

  always @(posedge clk) begin
    if (!bq[1]) begin
      m_cnt <= 8'h00;
      m_sel <= 4'h0;
      for (int c = 0; c < 2; c++) begin
        m_pend[c] <= 8'h80;
        m_act[c]  <= 8'h80;
      end
    end else begin
      m_cnt <= m_cnt + 8'd1;
      for (int c = 0; c < 2; c++) begin
        logic [7:0] nd;
        nd = (wr_en && addr == 2'(c + 1)) ? wr_data : m_pend[c];
        m_pend[c] <= nd;
        if (m_cnt == 8'hFF) m_act[c] <= nd;
      end
      if (wr_en && addr == 2'd3) m_sel <= wr_data[3:0];
    end
  end

  function automatic logic exp_drv(int p);
    case (m_sel[2*p +: 2])
      2'b00:   return 1'b0;
      2'b01:   return 1'b1;
      2'b10:   return m_cnt < m_act[0];
      default: return m_cnt < m_act[1];
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(logic [1:0] a);
    logic [1:0] e;
    e = {exp_drv(1), exp_drv(0)};
    case (a)
      2'd0:    return {6'b0, ~e & ext_level};
      2'd1:    return m_pend[0];
      2'd2:    return m_pend[1];
      default: return {4'hF, m_sel};
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Every-cycle pad check (R3 R5)
  always @(negedge clk) begin
    if (chk_on) begin
      for (int p = 0; p < 2; p++)
        check(drv_low[p] == exp_drv(p), "R3/R5 pad drive", {7'b0, drv_low[p]}, {7'b0, exp_drv(p)});
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, string tag);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    #1;
    check(rd_data == exp_rd(a), tag, rd_data, exp_rd(a));
  endtask

  task automatic count_low(int p, int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (drv_low[p]) lows++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    finish_run();
  end

  initial begin
    int lows;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    // R1: pads released during reset
    check(drv_low == 2'b00, "R1 reset drive", {6'b0, drv_low}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check(drv_low == 2'b00, "R1 sync release drive", {6'b0, drv_low}, 8'h00);
    repeat (2) @(negedge clk);
    chk_on = 1'b1;
    rd(2'd1, "R1 duty0 default");
    rd(2'd2, "R1 duty1 default");
    rd(2'd3, "R1 source default");
    rd(2'd0, "R8 pad input");

    // R6: reserved bits ignored
    wr(2'd3, 8'hA5);
    rd(2'd3, "R6 reserved readback");
    check(drv_low == 2'b11, "R5 both forced low", {6'b0, drv_low}, 8'h03);
    // R8: writes to input address have no effect
    wr(2'd0, 8'hFF);
    ext_level = 2'b10;
    rd(2'd0, "R8 pad input after write");
    ext_level = 2'b11;
    wr(2'd3, 8'h00);
    rd(2'd0, "R8 released pads read high");

    // pad0 follows waveform 0, pad1 forced low
    wr(2'd3, 8'h06);
    wr(2'd1, 8'h80);
    rd(2'd1, "R9 duty0 address");
    repeat (300) @(negedge clk);
    count_low(0, 256, lows);
    check(lows == 128, "R2 period of 256", 8'(lows), 8'd128);

    wr(2'd1, 8'h00);
    rd(2'd1, "R7 immediate readback");
    repeat (300) @(negedge clk);
    count_low(0, 256, lows);
    check(lows == 0, "R4 duty 00h", 8'(lows), 8'd0);

    wr(2'd1, 8'hFF);
    repeat (300) @(negedge clk);
    count_low(0, 256, lows);
    check(lows == 255, "R4 duty FFh", 8'(lows), 8'd255);

    // R7: write landing on the wrap edge
    do @(negedge clk); while (m_cnt != 8'hFF);
    wr_en = 1'b1; addr = 2'd1; wr_data = 8'h40;
    count_low(0, 256, lows);
    check(lows == 64, "R7 write on wrap edge", 8'(lows), 8'd64);

    // R7: mid-period write deferred to next wrap
    do @(negedge clk); while (m_cnt != 8'h05);
    wr_en = 1'b1; addr = 2'd1; wr_data = 8'hC0;
    count_low(0, 250, lows);
    check(lows == 58, "R7 old duty holds", 8'(lows), 8'd58);
    count_low(0, 256, lows);
    check(lows == 192, "R7 new duty after wrap", 8'(lows), 8'd192);

    // waveform 1 on pad1 (R5 code 11)
    wr(2'd2, 8'h20);
    wr(2'd3, 8'h0E);
    repeat (300) @(negedge clk);
    count_low(1, 256, lows);
    check(lows == 32, "R5 pad1 follows waveform 1", 8'(lows), 8'd32);

    // Constrained random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      ext_level = 2'($urandom);
      if ($urandom_range(7) == 0) begin
        int k;
        k = $urandom_range(3);
        wr_en = 1'b1;
        addr = 2'($urandom);
        wr_data = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'($urandom);
      end else begin
        wr_en = 1'b0;
        addr = 2'($urandom);
        #1;
        check(rd_data == exp_rd(addr), "R9 random read", rd_data, exp_rd(addr));
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    repeat (4) @(negedge clk);
    chk_on = 1'b0;
    finish_run();
  end

endmodule